// File: doc/BRIEF.md
# Floating-Point Register-List Transfer Sequencer

This block moves floating-point state between a bank of eight 96-bit registers and a 32-bit memory port. A single decoded extension word selects one of two operation classes. The first is a multi-register move that walks an 8-bit register list. The second is a control-register move that transfers any subset of three 32-bit control registers: control, status and instruction-address. After a one-cycle `start`, the sequencer checks the request for legality. It then issues one memory transfer per 32-bit word over a request/ready handshake and steps an address pointer as it goes. It ends with a one-cycle `done`, which carries `illegal` or `err` when the move did not complete normally.

The list can come straight from the extension word or from the low byte of a data register that the sequencer names on `dreg_idx`. The address mode (`ea_mode`: 0 data-register direct, 1 address-register direct, 2 indirect, 3 postincrement, 4 predecrement, 5 to 7 treated as indirect) sets the walk order and the stepping of the pointer. The block does no effective-address arithmetic beyond that stepping. `final_addr` gives the updated pointer so that the caller can write it back.

Top module: `fpx_xfer_seq`

## Requirements
- R1: Extension bit 15 must be 1, otherwise the request is illegal. Bit 14 = 1 selects a floating-point list move and bit 14 = 0 selects a control-register move. Bit 13 = 1 moves registers to memory (`mem_we` = 1) and bit 13 = 0 moves memory to registers.
- R2: When bit 11 is 1, the list is `dreg_byte`, and `dreg_idx` equals extension bits 6..4. Otherwise the list is extension bits 7..0.
- R3: List bits are served from bit 7 down to bit 0. In predecrement mode list bit k names register k; in every other mode it names register 7-k.
- R4: Each listed register moves as three words, bits 95..64 first and bits 31..0 last. A load writes the register exactly once, on the cycle its third word is accepted, with data {word0, word1, word2}.
- R5: With a stepping mode (2 to 7) and no predecrement, the word addresses are `base_addr` + 4·n and `final_addr` = `base_addr` + 4·(words). In predecrement mode, block j (from 1) starts at `base_addr` − B·j, its words ascend by 4, and `final_addr` = `base_addr` − B·(blocks). B is 12 per floating-point register, or 4·count for the single control-register block. Direct modes (0, 1) use `base_addr` for every word and leave it unchanged.
- R6: The control move select is extension bits 12..10. Bit 2 selects control, bit 1 selects status and bit 0 selects instruction-address, and a select of 0 means instruction-address alone. Words move in the order control, status, instruction-address, one word per selected register, for a count of 3, 2 or 1.
- R7: A loaded control word is ANDed with 0x0000FFF0 and a loaded status word with 0x0FFFFFF8 before `cr_wr_data` is written. `cr_wr_en` is one-hot {control, status, instruction-address}.
- R8: A transfer accepted with `mem_err` = 1 ends the move. `done` and `err` rise in the next cycle, no further request is made, and neither that word nor a partly loaded register is written.
- R9: A floating-point list move is illegal in direct modes, in postincrement mode toward memory, and in predecrement mode toward registers.
- R10: A control move is illegal in data-register direct mode when more than one word is selected, and in address-register direct mode unless the effective select is instruction-address alone.
- R11: An illegal request, or a floating-point move with an empty list, raises `done` in the cycle after `start` with no memory request. `illegal` is 1 only in the first case.
- R12: While `mem_req` is 1 and `mem_ready` is 0, `mem_req`, `mem_addr` and `mem_we` hold in the next cycle.
- R13: `done` is a one-cycle pulse, `illegal` and `err` are only seen with `done`, and there is no request while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a move (taken when idle) |
| ext_word | input | 16 | Decoded extension word |
| ea_mode | input | 3 | Address mode class |
| base_addr | input | 32 | Starting pointer value |
| dreg_idx | output | 3 | Data register supplying a dynamic list |
| dreg_byte | input | 8 | Low byte of that data register |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Transfer accepted this cycle |
| mem_err | input | 1 | Accepted transfer failed |
| mem_rdata | input | 32 | Load data |
| fr_rd_idx | output | 3 | Register-file read index |
| fr_rd_data | input | 96 | Register-file read data |
| fr_wr_en | output | 1 | Register-file write strobe |
| fr_wr_idx | output | 3 | Register-file write index |
| fr_wr_data | output | 96 | Register-file write data |
| cr_rd_ctl | input | 32 | Control register value |
| cr_rd_sts | input | 32 | Status register value |
| cr_rd_iar | input | 32 | Instruction-address register value |
| cr_wr_en | output | 3 | One-hot write {control, status, iar} |
| cr_wr_data | output | 32 | Masked control-register write data |
| done | output | 1 | Move finished (pulse) |
| illegal | output | 1 | Request rejected (with done) |
| err | output | 1 | Move stopped by memory error (with done) |
| final_addr | output | 32 | Pointer after the move |

## Verification
The bench sweeps all 256 static lists under predecrement stores, indirect stores and postincrement loads. If the walk direction were not reversed under predecrement, registers would land at mirrored addresses. If the block-wise downward step were wrong, the words of a register would come out reversed, or `final_addr` would be off by a multiple of 12. Every dynamic-list source index and every select, direction and mode combination of the control path are covered. A wrong zero-select rule, word count or order would shift the words, and a missing mask would leave the reserved bits set. Memory errors injected mid-register show whether a design writes a half-loaded register or keeps requesting after the failure.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int WORD_W   = 32;
    localparam int NREG     = 8;
    localparam int IDX_W    = $clog2(NREG);
    localparam int FR_WORDS = 3;
    localparam int FR_W     = WORD_W * FR_WORDS;
    localparam int ACC_W    = WORD_W * (FR_WORDS - 1);
    localparam int CR_N     = 3;
    localparam int CRP_W    = $clog2(CR_N);
    localparam int WCNT_W   = 2;
    localparam int EXT_W    = 16;
    localparam int MODE_W   = 3;
    localparam logic [WORD_W-1:0] FR_BLK_BYTES = WORD_W'(FR_WORDS * 4);
    localparam logic [WORD_W-1:0] CTL_KEEP     = 32'h0000_FFF0;
    localparam logic [WORD_W-1:0] STS_KEEP     = 32'h0FFF_FFF8;

    typedef enum logic [MODE_W-1:0] {
        AM_DDIR    = 3'd0,
        AM_ADIR    = 3'd1,
        AM_IND     = 3'd2,
        AM_POSTINC = 3'd3,
        AM_PREDEC  = 3'd4
    } amode_e;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_MOVE = 1'b1
    } sq_state_e;

    typedef struct packed {
        sq_state_e           st;
        logic                is_fp;
        logic                to_mem;
        logic                predec;
        logic                step;
        logic [NREG-1:0]     list;
        logic [CR_N-1:0]     cr;
        logic [WCNT_W-1:0]   w;
        logic [WORD_W-1:0]   ptr;
        logic [ACC_W-1:0]    acc;
        logic                done;
        logic                illegal;
        logic                err;
    } sq_ctx_t;
endpackage

// File: rtl/fpx_msb_pick.sv
module fpx_msb_pick #(
    parameter int W   = 8,
    parameter int P_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]   vec,
    output logic [P_W-1:0] pos,
    output logic           any
);
    always_comb begin
        pos = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos = P_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpx_xfer_decode.sv
module fpx_xfer_decode
    import fpx_pkg::*;
(
    input  logic [EXT_W-1:0]  ext,
    input  logic [MODE_W-1:0] mode,
    input  logic [NREG-1:0]   dyn_list,
    output logic              is_fp,
    output logic              to_mem,
    output logic              predec,
    output logic              step,
    output logic [NREG-1:0]   list,
    output logic [CR_N-1:0]   cr_sel,
    output logic [WCNT_W-1:0] cr_cnt,
    output logic              bad
);
    logic unused_ext_bits;
    logic is_ddir, is_adir, is_post;
    logic fp_bad, cr_bad;

    assign unused_ext_bits = ^ext[9:8];

    assign is_fp   = ext[14];
    assign to_mem  = ext[13];
    assign is_ddir = (mode == AM_DDIR);
    assign is_adir = (mode == AM_ADIR);
    assign is_post = (mode == AM_POSTINC);
    assign predec  = (mode == AM_PREDEC);
    assign step    = !(is_ddir || is_adir);

    assign list    = ext[11] ? dyn_list : ext[NREG-1:0];
    assign cr_sel  = (ext[12:10] == '0) ? CR_N'(1) : ext[12:10];

    always_comb begin
        cr_cnt = '0;
        for (int i = 0; i < CR_N; i++) begin
            cr_cnt = cr_cnt + WCNT_W'(cr_sel[i]);
        end
    end

    assign fp_bad = is_ddir || is_adir || (to_mem && is_post) || (!to_mem && predec);
    assign cr_bad = (is_ddir && (cr_cnt > WCNT_W'(1))) ||
                    (is_adir && (cr_sel != CR_N'(1)));
    assign bad    = !ext[15] || (is_fp ? fp_bad : cr_bad);
endmodule

// File: rtl/fpx_xfer_seq.sv
module fpx_xfer_seq
    import fpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [EXT_W-1:0]    ext_word,
    input  logic [MODE_W-1:0]   ea_mode,
    input  logic [WORD_W-1:0]   base_addr,
    output logic [IDX_W-1:0]    dreg_idx,
    input  logic [NREG-1:0]     dreg_byte,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic                mem_err,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [IDX_W-1:0]    fr_rd_idx,
    input  logic [FR_W-1:0]     fr_rd_data,
    output logic                fr_wr_en,
    output logic [IDX_W-1:0]    fr_wr_idx,
    output logic [FR_W-1:0]     fr_wr_data,
    input  logic [WORD_W-1:0]   cr_rd_ctl,
    input  logic [WORD_W-1:0]   cr_rd_sts,
    input  logic [WORD_W-1:0]   cr_rd_iar,
    output logic [CR_N-1:0]     cr_wr_en,
    output logic [WORD_W-1:0]   cr_wr_data,
    output logic                done,
    output logic                illegal,
    output logic                err,
    output logic [WORD_W-1:0]   final_addr
);
    sq_ctx_t q, d;

    logic              dc_is_fp, dc_to_mem, dc_predec, dc_step, dc_bad;
    logic [NREG-1:0]   dc_list;
    logic [CR_N-1:0]   dc_cr;
    logic [WCNT_W-1:0] dc_cnt;

    logic [IDX_W-1:0]  fp_pos;
    logic              fp_any;
    logic [CRP_W-1:0]  cr_pos;
    logic              cr_any;
    logic [IDX_W-1:0]  cur_reg;
    logic [NREG-1:0]   list_left;
    logic [CR_N-1:0]   cr_left;
    logic [CR_N-1:0]   cr_hot;
    logic [WORD_W-1:0] fr_word;
    logic [WORD_W-1:0] cr_word;
    logic [WORD_W-1:0] cr_keep;
    logic [WORD_W-1:0] blk_bytes;
    logic              xfer_ok;

    assign dreg_idx = ext_word[6:4];

    fpx_xfer_decode u_dec (
        .ext      (ext_word),
        .mode     (ea_mode),
        .dyn_list (dreg_byte),
        .is_fp    (dc_is_fp),
        .to_mem   (dc_to_mem),
        .predec   (dc_predec),
        .step     (dc_step),
        .list     (dc_list),
        .cr_sel   (dc_cr),
        .cr_cnt   (dc_cnt),
        .bad      (dc_bad)
    );

    fpx_msb_pick #(.W(NREG)) u_fp_pick (
        .vec (q.list),
        .pos (fp_pos),
        .any (fp_any)
    );

    fpx_msb_pick #(.W(CR_N)) u_cr_pick (
        .vec (q.cr),
        .pos (cr_pos),
        .any (cr_any)
    );

    // Register index for the list bit being served: mirrored outside predecrement.
    assign cur_reg   = q.predec ? fp_pos : IDX_W'(NREG - 1) - fp_pos;
    assign list_left = q.list & ~(NREG'(1) << fp_pos);
    assign cr_hot    = CR_N'(1) << cr_pos;
    assign cr_left   = q.cr & ~cr_hot;
    assign fr_rd_idx = cur_reg;

    always_comb begin
        case (q.w)
            WCNT_W'(0): fr_word = fr_rd_data[FR_W-1 -: WORD_W];
            WCNT_W'(1): fr_word = fr_rd_data[FR_W-WORD_W-1 -: WORD_W];
            default:    fr_word = fr_rd_data[WORD_W-1:0];
        endcase
    end

    always_comb begin
        case (cr_pos)
            CRP_W'(2): begin cr_word = cr_rd_ctl; cr_keep = CTL_KEEP;  end
            CRP_W'(1): begin cr_word = cr_rd_sts; cr_keep = STS_KEEP;  end
            default:   begin cr_word = cr_rd_iar; cr_keep = '1;        end
        endcase
    end

    assign blk_bytes = dc_is_fp ? FR_BLK_BYTES : WORD_W'({dc_cnt, 2'b00});
    assign xfer_ok   = (q.st == SQ_MOVE) && mem_ready && !mem_err;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.illegal = 1'b0;
        d.err     = 1'b0;

        mem_req    = (q.st == SQ_MOVE);
        mem_we     = q.to_mem;
        mem_addr   = q.ptr + (q.predec ? WORD_W'({q.w, 2'b00}) : '0);
        mem_wdata  = q.is_fp ? fr_word : cr_word;

        fr_wr_en   = xfer_ok && q.is_fp && !q.to_mem && (q.w == WCNT_W'(FR_WORDS - 1));
        fr_wr_idx  = cur_reg;
        fr_wr_data = {q.acc, mem_rdata};
        cr_wr_en   = (xfer_ok && !q.is_fp && !q.to_mem && cr_any) ? cr_hot : '0;
        cr_wr_data = mem_rdata & cr_keep;

        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    if (dc_bad) begin
                        d.done    = 1'b1;
                        d.illegal = 1'b1;
                    end else if (dc_is_fp && (dc_list == '0)) begin
                        d.done = 1'b1;
                        d.ptr  = base_addr;
                    end else begin
                        d.st     = SQ_MOVE;
                        d.is_fp  = dc_is_fp;
                        d.to_mem = dc_to_mem;
                        d.predec = dc_predec;
                        d.step   = dc_step;
                        d.list   = dc_list;
                        d.cr     = dc_cr;
                        d.w      = '0;
                        d.acc    = '0;
                        d.ptr    = dc_predec ? (base_addr - blk_bytes) : base_addr;
                    end
                end
            end
            SQ_MOVE: begin
                if (mem_ready) begin
                    if (mem_err) begin
                        d.st   = SQ_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        if (q.step && !q.predec) begin
                            d.ptr = q.ptr + WORD_W'(4);
                        end
                        if (q.is_fp) begin
                            if (q.w == WCNT_W'(0)) begin
                                d.acc[ACC_W-1 -: WORD_W] = mem_rdata;
                            end else if (q.w == WCNT_W'(1)) begin
                                d.acc[WORD_W-1:0] = mem_rdata;
                            end
                            if (q.w == WCNT_W'(FR_WORDS - 1)) begin
                                d.w    = '0;
                                d.list = list_left;
                                if (list_left == '0) begin
                                    d.st   = SQ_IDLE;
                                    d.done = 1'b1;
                                end else if (q.predec) begin
                                    d.ptr = q.ptr - FR_BLK_BYTES;
                                end
                            end else begin
                                d.w = q.w + WCNT_W'(1);
                            end
                        end else begin
                            d.cr = cr_left;
                            d.w  = q.w + WCNT_W'(1);
                            if (cr_left == '0) begin
                                d.st   = SQ_IDLE;
                                d.done = 1'b1;
                            end
                        end
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done       = q.done;
    assign illegal    = q.illegal;
    assign err        = q.err;
    assign final_addr = q.ptr;

    logic unused_any;
    assign unused_any = fp_any;
endmodule

// File: rtl/fpx_xfer_seq_chk.sv
module fpx_xfer_seq_chk
    import fpx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              mem_err,
    input logic              fr_wr_en,
    input logic [CR_N-1:0]   cr_wr_en,
    input logic [WORD_W-1:0] cr_wr_data,
    input logic              done,
    input logic              illegal,
    input logic              err
);
    // R12: an unanswered request holds its address and direction
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: a failed transfer ends the move with no further request
    p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err) |=> (!mem_req && done && err));

    // R8: nothing is written on a failed transfer
    p_no_wr_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && mem_err) |-> (!fr_wr_en && (cr_wr_en == '0)));

    // R13: done is a single-cycle pulse
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: flags only with done, and no request while done
    p_flags_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal || err) |-> (done && !mem_req));

    // R4: a register write needs an accepted load transfer
    p_fr_wr_on_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_wr_en |-> (mem_req && mem_ready && !mem_we));

    // R7: at most one control register written, with its reserved bits cleared
    p_cr_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en != '0) |-> ($onehot0(cr_wr_en) &&
            (!cr_wr_en[2] || ((cr_wr_data & ~CTL_KEEP) == '0)) &&
            (!cr_wr_en[1] || ((cr_wr_data & ~STS_KEEP) == '0))));
endmodule

bind fpx_xfer_seq fpx_xfer_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready),
    .mem_err    (mem_err),
    .fr_wr_en   (fr_wr_en),
    .cr_wr_en   (cr_wr_en),
    .cr_wr_data (cr_wr_data),
    .done       (done),
    .illegal    (illegal),
    .err        (err)
);

// File: tb/fpx_xfer_seq_test.sv
module fpx_xfer_seq_test;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ext_i = '0;
    logic [2:0]  mode_i = '0;
    logic [31:0] base_i = '0;
    logic [2:0]  dreg_idx;
    logic [7:0]  dreg_byte;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  fr_rd_idx, fr_wr_idx;
    logic [95:0] fr_rd_data, fr_wr_data;
    logic        fr_wr_en;
    logic [31:0] ctl_r, sts_r, iar_r;
    logic [2:0]  cr_wr_en;
    logic [31:0] cr_wr_data;
    logic        done, illegal, err;
    logic [31:0] final_addr;

    logic [95:0] frf [8];
    logic [31:0] lg_addr [64];
    logic        lg_we   [64];
    logic [31:0] lg_wd   [64];
    int          lcnt;
    int          nchk = 0, nfail = 0;
    logic        r_done, r_ill, r_err;
    logic [31:0] r_fin;

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] dyn_of(input logic [2:0] i);
        return 8'h3C ^ (8'(i) * 8'h1D);
    endfunction
    function automatic logic [95:0] fr_init(input int i);
        return {24'hA0A0A0, 8'(i), 24'hB1B1B1, 8'(i), 24'hC2C2C2, 8'(i)};
    endfunction
    function automatic logic [31:0] mem_of(input logic [31:0] a);
        return 32'hF5A5_0007 ^ {a[27:0], 4'h0};
    endfunction
    function automatic logic [31:0] fr_w(input logic [95:0] v, input int w);
        return (w == 0) ? v[95:64] : (w == 1) ? v[63:32] : v[31:0];
    endfunction

    assign dreg_byte  = dyn_of(dreg_idx);
    assign fr_rd_data = frf[fr_rd_idx];

    fpx_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_word(ext_i), .ea_mode(mode_i),
        .base_addr(base_i), .dreg_idx(dreg_idx), .dreg_byte(dreg_byte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .fr_rd_idx(fr_rd_idx), .fr_rd_data(fr_rd_data), .fr_wr_en(fr_wr_en),
        .fr_wr_idx(fr_wr_idx), .fr_wr_data(fr_wr_data),
        .cr_rd_ctl(ctl_r), .cr_rd_sts(sts_r), .cr_rd_iar(iar_r),
        .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data),
        .done(done), .illegal(illegal), .err(err), .final_addr(final_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one move, answering the memory port and capturing register writes.
    task automatic run(input logic [15:0] ext, input logic [2:0] mode,
                       input logic [31:0] base, input int lat, input int err_at);
        int wc = 0;
        for (int i = 0; i < 8; i++) frf[i] = fr_init(i);
        ctl_r = 32'h1357_9BDF; sts_r = 32'h2468_ACE0; iar_r = 32'h0BAD_F00D;
        lcnt = 0; r_done = 0; r_ill = 0; r_err = 0; r_fin = '0;
        @(negedge clk);
        ext_i = ext; mode_i = mode; base_i = base; start = 1'b1;
        for (int c = 0; c < 400; c++) begin
            @(posedge clk);
            if (fr_wr_en) frf[fr_wr_idx] = fr_wr_data;
            if (cr_wr_en[2]) ctl_r = cr_wr_data;
            if (cr_wr_en[1]) sts_r = cr_wr_data;
            if (cr_wr_en[0]) iar_r = cr_wr_data;
            @(negedge clk);
            start = 1'b0;
            mem_ready = 1'b0; mem_err = 1'b0;
            if (done) begin
                r_done = 1; r_ill = illegal; r_err = err; r_fin = final_addr;
                break;
            end
            if (mem_req) begin
                if (wc < lat) wc++;
                else begin
                    wc = 0;
                    mem_ready = 1'b1;
                    mem_err   = (lcnt == err_at);
                    mem_rdata = mem_of(mem_addr);
                    if (lcnt < 64) begin
                        lg_addr[lcnt] = mem_addr; lg_we[lcnt] = mem_we; lg_wd[lcnt] = mem_wdata;
                    end
                    lcnt++;
                end
            end
        end
    endtask

    // R1 R2 R3 R4 R5 R8 R9 R11: floating-point list move against an arithmetic model
    task automatic fp_case(input bit tm, input bit dyn, input logic [7:0] lst_or_idx,
                           input logic [2:0] mode, input logic [31:0] base,
                           input int lat, input int err_at, input string tag);
        logic [15:0] ext;
        logic [7:0]  lst;
        logic [95:0] efr [8];
        logic [31:0] part [3];
        logic [31:0] a;
        bit pre, bad, stop, seq_ok, experr;
        int n, j, r;
        ext = 16'hC000 | (16'(tm) << 13) | (16'(dyn) << 11) | 16'(lst_or_idx);
        lst = dyn ? dyn_of(lst_or_idx[6:4]) : lst_or_idx;
        pre = (mode == 3'd4);
        bad = (mode <= 3'd1) || (tm && mode == 3'd3) || (!tm && pre);
        run(ext, mode, base, lat, err_at);
        chk(r_done, {tag, " R13 done seen"}, 128'(r_done), 128'd1);
        chk(r_ill == bad, {tag, " R9 illegal"}, 128'(r_ill), 128'(bad));
        if (bad) begin
            chk(lcnt == 0, {tag, " R11 no request when illegal"}, 128'(lcnt), 128'd0);
            return;
        end
        for (int i = 0; i < 8; i++) efr[i] = fr_init(i);
        n = 0; j = 0; stop = 0; seq_ok = 1; experr = 0;
        for (int k = 7; k >= 0; k--) begin
            if (lst[k] && !stop) begin
                r = pre ? k : 7 - k;
                j++;
                for (int w = 0; w < 3; w++) begin
                    if (!stop) begin
                        a = pre ? (base - 32'(12 * j) + 32'(4 * w)) : (base + 32'(4 * n));
                        if (n >= lcnt || lg_addr[n] != a || lg_we[n] != tm ||
                            (tm && lg_wd[n] != fr_w(fr_init(r), w))) seq_ok = 0;
                        if (n == err_at) begin
                            experr = 1; stop = 1;
                        end else begin
                            part[w] = mem_of(a);
                        end
                        n++;
                    end
                end
                if (!stop && !tm) efr[r] = {part[0], part[1], part[2]};
            end
        end
        chk(seq_ok && lcnt == n, {tag, " R3 R4 R5 word sequence"}, 128'(lcnt), 128'(n));
        chk(r_err == experr, {tag, " R8 err flag"}, 128'(r_err), 128'(experr));
        for (int i = 0; i < 8; i++)
            if (frf[i] != efr[i]) begin
                chk(0, {tag, " R4 register file"}, 128'(frf[i]), 128'(efr[i]));
                break;
            end
        if (!experr) begin
            a = pre ? base - 32'(12 * j) : base + 32'(4 * n);
            chk(r_fin == a, {tag, " R5 final_addr"}, 128'(r_fin), 128'(a));
        end
    endtask

    // R6 R7 R10: control-register move
    task automatic cr_case(input bit tm, input logic [2:0] sel, input logic [2:0] mode,
                           input logic [31:0] base, input int lat, input string tag);
        logic [2:0]  eff;
        logic [31:0] a, v, ectl, ests, eiar;
        int cnt, n;
        bit bad, seq_ok;
        eff = (sel == 0) ? 3'b001 : sel;
        cnt = int'(eff[0]) + int'(eff[1]) + int'(eff[2]);
        bad = (mode == 3'd0 && cnt > 1) || (mode == 3'd1 && eff != 3'b001);
        run(16'h8000 | (16'(tm) << 13) | (16'(sel) << 10), mode, base, lat, -1);
        chk(r_ill == bad, {tag, " R10 illegal"}, 128'(r_ill), 128'(bad));
        if (bad) begin
            chk(lcnt == 0, {tag, " R11 no request"}, 128'(lcnt), 128'd0);
            return;
        end
        ectl = 32'h1357_9BDF; ests = 32'h2468_ACE0; eiar = 32'h0BAD_F00D;
        n = 0; seq_ok = 1;
        for (int b = 2; b >= 0; b--) begin
            if (eff[b]) begin
                a = (mode == 3'd4) ? base - 32'(4 * cnt) + 32'(4 * n) :
                    (mode <= 3'd1) ? base : base + 32'(4 * n);
                v = (b == 2) ? ectl : (b == 1) ? ests : eiar;
                if (n >= lcnt || lg_addr[n] != a || lg_we[n] != tm || (tm && lg_wd[n] != v))
                    seq_ok = 0;
                if (!tm) begin
                    if (b == 2) ectl = mem_of(a) & 32'h0000_FFF0;
                    if (b == 1) ests = mem_of(a) & 32'h0FFF_FFF8;
                    if (b == 0) eiar = mem_of(a);
                end
                n++;
            end
        end
        chk(seq_ok && lcnt == n, {tag, " R6 word order and count"}, 128'(lcnt), 128'(n));
        chk(ctl_r == ectl && sts_r == ests && iar_r == eiar, {tag, " R7 masked registers"},
            {32'd0, ctl_r, sts_r, iar_r}, {32'd0, ectl, ests, eiar});
        a = (mode == 3'd4) ? base - 32'(4 * cnt) : (mode <= 3'd1) ? base : base + 32'(4 * cnt);
        chk(r_fin == a, {tag, " R5 control final_addr"}, 128'(r_fin), 128'(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !illegal && !err, "reset R13 outputs idle",
            {done, mem_req, illegal, err}, 4'b0);
        rst_n = 1'b1;
        // R3 R4 R5: full static-list sweep, three mode/direction pairs
        for (int l = 0; l < 256; l++) begin
            fp_case(1, 0, 8'(l), 3'd4, 32'h0000_0200, l % 2, -1, "fp store predec");
            fp_case(1, 0, 8'(l), 3'd2, 32'h0000_0100, (l / 2) % 2, -1, "fp store indirect");
            fp_case(0, 0, 8'(l), 3'd3, 32'h0000_0100, (l / 4) % 2, -1, "fp load postinc");
        end
        // R2: every dynamic source register
        for (int i = 0; i < 8; i++) begin
            fp_case(1, 1, 8'(i << 4), 3'd4, 32'h0000_0200, 0, -1, "R2 dyn store");
            fp_case(0, 1, 8'(i << 4), 3'd2, 32'h0000_0100, 1, -1, "R2 dyn load");
        end
        // R9: illegal floating-point modes
        fp_case(1, 0, 8'hFF, 3'd3, 32'h100, 0, -1, "R9 store postinc");
        fp_case(0, 0, 8'hFF, 3'd4, 32'h200, 0, -1, "R9 load predec");
        fp_case(0, 0, 8'h81, 3'd0, 32'h100, 0, -1, "R9 data direct");
        fp_case(1, 0, 8'h81, 3'd1, 32'h100, 0, -1, "R9 addr direct");
        // R1: missing class bit 15 is illegal
        run(16'h4000 | 16'h00FF, 3'd2, 32'h100, 0, -1);
        chk(r_done && r_ill && lcnt == 0, "R1 bit15 clear rejected", {r_ill, 8'(lcnt)}, 9'h100);
        // R8: errors mid-register
        for (int e = 0; e < 7; e++) begin
            fp_case(0, 0, 8'hA5, 3'd3, 32'h100, e % 2, e, "R8 load error");
            fp_case(1, 0, 8'hC3, 3'd4, 32'h200, 0, e, "R8 store error");
        end
        // R6 R7 R10: control path sweep
        for (int s = 0; s < 8; s++)
            for (int dir = 0; dir < 2; dir++)
                for (int m = 0; m < 5; m++)
                    cr_case(dir[0], 3'(s), 3'(m), 32'h0000_0180, (s + m) % 2, "ctl");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule